// File: doc/BRIEF.md
# I2C Target Port with Software Clock Hold

This block is a byte-wide I2C target (slave) for a microcontroller-style peripheral. The SCL and SDA lines are sampled through a short synchronizer. The block finds Start and Stop conditions, compares the incoming address against a 7-bit or 10-bit own address, and then either receives bytes into a single receive buffer or shifts bytes out of a transmit holding register. Each pad is modelled as an open-drain line. The block only ever pulls a line low, so each line has an input and an output-enable. There is no driven output level.

Software controls the block through one 8-bit control word. It holds the port enable, a clock-release bit, two sticky error flags and a 4-bit mode. When the clock-release bit is 0 and the port is active, the block holds SCL low. Software sets the bit once it has serviced the current byte. Before each byte it transmits, the block clears the bit itself.

Data moves through two streams:
- **Receive stream.** `rx_valid` stays high while the receive buffer holds an unread byte. A cycle with `rx_valid` and `rx_ready` both high consumes that byte.
- **Transmit stream.** `tx_ready` is always high, so a write is never back-pressured. A write that arrives while the previous byte is still being shifted out is dropped and raises the write-collision flag. A write made outside transmit is discarded.

Top module: `i2c_target_port`

## Requirements
- R1: After reset, `ctrl_rdata` reads 0x00, `rx_valid` is 0, and neither `scl_oe` nor `sda_oe` is asserted.
- R2: When the enable bit (bit 7) is 0, the port is inactive. It is also inactive when the mode field (bits 3:0) holds a code other than 0110, 0111, 1110 or 1111. While inactive it never asserts `scl_oe` or `sda_oe` and does not acknowledge any address.
- R3: While the port is active, a clock-release bit (bit 6) of 0 makes the block hold SCL low, and a 1 releases SCL.
- R4: In 7-bit modes (0110, 1110), an address byte whose upper seven bits equal `own_addr[6:0]` with R/W=0 is acknowledged. Each following data byte is acknowledged and placed on `rx_data` with `rx_valid` high. `irq_byte` pulses once per matched address and once per completed data byte.
- R5: An address byte that does not match is not acknowledged. The block then neither acknowledges nor pulses `irq_byte` until the next Start.
- R6: After a matching address with R/W=1, the block clears the clock-release bit and holds SCL. Once software loads a byte and sets the bit, the byte is sent MSB first. After each byte the master acknowledges, the bit is cleared again.
- R7: A transmit write made while a byte is still being shifted out sets the write-collision flag (bit 5) and leaves the byte being sent unchanged. The flag stays set until software writes 0 to it. If hardware sets the flag in the same cycle as a software clear, the flag is set.
- R8: When a data byte completes while `rx_valid` is still high, the block sets the overflow flag (bit 4), does not acknowledge that byte, and keeps the old `rx_data`. The flag stays set until software writes 0 to it.
- R9: Transmit writes made during a receive transfer do not set the write-collision flag. A transmit transfer does not set the overflow flag, even while `rx_valid` is high.
- R10: In 10-bit modes (0111, 1111) the address is matched in two steps. The first byte must be 11110, then `own_addr[9:8]`, then R/W=0. The second byte must equal `own_addr[7:0]`. After that, a repeated Start followed by 11110, `own_addr[9:8]` and R/W=1 enters transmit. A first byte with other high bits is not acknowledged.
- R11: In modes 1110 and 1111 only, `irq_start` pulses on each Start and `irq_stop` pulses on each Stop.
- R12: The control word is laid out as en[7], release[6], collision[5], overflow[4], mode[3:0]. A write loads en, release and mode, and can only clear the two flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word write data |
| ctrl_rdata | output | 8 | Control word readback |
| own_addr | input | 10 | Own address (7-bit modes use bits 6:0) |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Transmit accept, always 1 |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Receive buffer holds an unread byte |
| rx_ready | input | 1 | Consume receive byte |
| rx_data | output | 8 | Receive buffer |
| irq_byte | output | 1 | Pulse on matched address or completed byte |
| irq_start | output | 1 | Pulse on Start (modes 1110/1111) |
| irq_stop | output | 1 | Pulse on Stop (modes 1110/1111) |
| scl_i | input | 1 | SCL pad level |
| scl_oe | output | 1 | Pull SCL low |
| sda_i | input | 1 | SDA pad level |
| sda_oe | output | 1 | Pull SDA low |

## Verification
Two functions can land in the same cycle: a hardware setting of the collision flag and a software control write that clears it. The bench provokes this in the middle of a transmitted byte. It issues a transmit write and a control write with bit 5 at 0 on the same clock. It then expects the flag to read 1 and the master to receive the originally loaded byte. A reference model of activity, kept from the bench's own control writes, is compared with both output-enables on every clock.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_HDR, PH_LOW, PH_RECV, PH_SEND, PH_SKIP
  } phase_t;

  localparam int BYTE_W = 8;
  localparam int ADR_W  = 10;

  // control word bit positions
  localparam int CB_EN   = 7;
  localparam int CB_REL  = 6;
  localparam int CB_WCOL = 5;
  localparam int CB_OVF  = 4;

  function automatic logic mode_ok(input logic [3:0] m);
    return m[2] & m[1];
  endfunction
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= '1;
      else if (s == 0) pipe[s] <= d;
      else pipe[s] <= pipe[(s > 0) ? s - 1 : 0];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic start,
  output logic stop,
  output logic rise,
  output logic fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign start = scl & scl_q & sda_q & ~sda;
  assign stop  = scl & scl_q & ~sda_q & sda;
  assign rise  = scl & ~scl_q;
  assign fall  = ~scl & scl_q;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [7:0]        ctrl_wdata,
  output logic [7:0]        ctrl_rdata,
  input  logic [ADR_W-1:0]  own_addr,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic              irq_byte,
  output logic              irq_start,
  output logic              irq_stop,
  input  logic              s_sda,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_rise,
  input  logic              ev_fall,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam int CNT_W  = 4;
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_END  = CNT_W'(BYTE_W + 1);

  phase_t             ph;
  logic               en, rel, wcol, ovf;
  logic [3:0]         mode;
  logic [BYTE_W-1:0]  sh, rbuf;
  logic [CNT_W-1:0]   cnt;
  logic               rfull, ack_drv, busy, hi_done, m_nack;

  logic active, ten, sirq, hdr_ok;
  assign active = en & mode_ok(mode);
  assign ten    = mode[0];
  assign sirq   = mode[3];
  assign hdr_ok = (sh[7:3] == 5'b11110) && (sh[2:1] == own_addr[9:8]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; en <= 1'b0; rel <= 1'b0; wcol <= 1'b0; ovf <= 1'b0;
      mode <= '0; sh <= '0; rbuf <= '0; cnt <= '0; rfull <= 1'b0;
      ack_drv <= 1'b0; busy <= 1'b0; hi_done <= 1'b0; m_nack <= 1'b0;
      irq_byte <= 1'b0; irq_start <= 1'b0; irq_stop <= 1'b0;
    end else begin
      irq_byte <= 1'b0; irq_start <= 1'b0; irq_stop <= 1'b0;
      if (ctrl_we) begin
        en   <= ctrl_wdata[CB_EN];
        rel  <= ctrl_wdata[CB_REL];
        wcol <= wcol & ctrl_wdata[CB_WCOL];
        ovf  <= ovf & ctrl_wdata[CB_OVF];
        mode <= ctrl_wdata[3:0];
      end
      if (rx_valid && rx_ready) rfull <= 1'b0;

      if (!active) begin
        ph <= PH_IDLE; cnt <= '0; ack_drv <= 1'b0; busy <= 1'b0; hi_done <= 1'b0;
      end else if (ev_start) begin
        ph <= PH_HDR; cnt <= '0; ack_drv <= 1'b0; busy <= 1'b0;
        irq_start <= sirq;
      end else if (ev_stop) begin
        ph <= PH_IDLE; cnt <= '0; ack_drv <= 1'b0; busy <= 1'b0; hi_done <= 1'b0;
        irq_stop <= sirq;
      end else begin
        if (tx_valid && ph == PH_SEND) begin
          if (busy) wcol <= 1'b1;
          else begin
            sh   <= tx_data;
            busy <= 1'b1;
          end
        end
        unique case (ph)
          PH_HDR, PH_LOW, PH_RECV: begin
            if (ev_rise && cnt < ACK_SLOT) begin
              sh  <= {sh[BYTE_W-2:0], s_sda};
              cnt <= cnt + 1'b1;
            end
            if (ev_fall && cnt == ACK_END) begin
              ack_drv <= 1'b0;
              cnt     <= '0;
            end
            if (ev_fall && cnt == ACK_SLOT) begin
              cnt <= ACK_END;
              if (ph == PH_HDR && !ten) begin
                if (sh[7:1] == own_addr[6:0]) begin
                  ack_drv <= 1'b1; irq_byte <= 1'b1;
                  ph <= sh[0] ? PH_SEND : PH_RECV;
                end else ph <= PH_SKIP;
              end else if (ph == PH_HDR) begin
                if (hdr_ok && !sh[0]) begin
                  ack_drv <= 1'b1; hi_done <= 1'b0; ph <= PH_LOW;
                end else if (hdr_ok && hi_done) begin
                  ack_drv <= 1'b1; irq_byte <= 1'b1; ph <= PH_SEND;
                end else begin
                  hi_done <= 1'b0; ph <= PH_SKIP;
                end
              end else if (ph == PH_LOW) begin
                if (sh == own_addr[7:0]) begin
                  ack_drv <= 1'b1; irq_byte <= 1'b1; hi_done <= 1'b1; ph <= PH_RECV;
                end else ph <= PH_SKIP;
              end else begin
                irq_byte <= 1'b1;
                if (rfull && !rx_ready) ovf <= 1'b1;
                else begin
                  rbuf <= sh; rfull <= 1'b1; ack_drv <= 1'b1;
                end
              end
            end
          end
          PH_SEND: begin
            if (ev_fall && cnt == ACK_END) begin
              ack_drv <= 1'b0;
              cnt     <= '0;
              rel     <= 1'b0;
            end else if (ev_fall && cnt < ACK_SLOT && busy) begin
              sh  <= {sh[BYTE_W-2:0], 1'b0};
              cnt <= cnt + 1'b1;
            end else if (ev_fall && cnt == ACK_SLOT) begin
              busy <= 1'b0; irq_byte <= 1'b1; cnt <= '0;
              if (m_nack) ph <= PH_SKIP;
              else rel <= 1'b0;
            end
            if (ev_rise && cnt == ACK_SLOT) m_nack <= s_sda;
          end
          default: ;
        endcase
      end
    end
  end

  assign scl_oe     = active & ~rel;
  assign sda_oe     = active & (ack_drv | (ph == PH_SEND && busy && cnt < ACK_SLOT && !sh[7]));
  assign rx_valid   = rfull;
  assign rx_data    = rbuf;
  assign ctrl_rdata = {en, rel, wcol, ovf, mode};

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !scl_oe && !sda_oe); // R2
  AST_WCOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wcol && !(ctrl_we && !ctrl_wdata[CB_WCOL]) |=> wcol); // R7
  AST_WCOL_ONLY_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wcol) |-> $past(ph == PH_SEND)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !(ctrl_we && !ctrl_wdata[CB_OVF]) |=> ovf); // R8
  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> $stable(rx_data) && rx_valid); // R8
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_byte, irq_start, irq_stop})); // R11
  AST_NO_SDA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ph == PH_IDLE |-> !sda_oe); // R5
endmodule

// File: rtl/i2c_target_port.sv
module i2c_target_port
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [7:0]        ctrl_wdata,
  output logic [7:0]        ctrl_rdata,
  input  logic [ADR_W-1:0]  own_addr,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic              irq_byte,
  output logic              irq_start,
  output logic              irq_stop,
  input  logic              scl_i,
  output logic              scl_oe,
  input  logic              sda_i,
  output logic              sda_oe
);
  logic [1:0] lines;
  logic ev_start, ev_stop, ev_rise, ev_fall;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(lines)
  );

  i2c_tgt_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl(lines[1]), .sda(lines[0]),
    .start(ev_start), .stop(ev_stop), .rise(ev_rise), .fall(ev_fall)
  );

  i2c_tgt_engine u_eng (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .own_addr(own_addr), .tx_valid(tx_valid), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .irq_byte(irq_byte), .irq_start(irq_start), .irq_stop(irq_stop),
    .s_sda(lines[0]), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_rise(ev_rise), .ev_fall(ev_fall),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  assign tx_ready = 1'b1;
endmodule

// File: tb/i2c_target_port_bench.sv
`timescale 1ns/1ps
module i2c_target_port_bench;
  localparam int H = 16;
  localparam logic [6:0] A7  = 7'h3A;
  localparam logic [9:0] A10 = 10'h2C5;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic ctrl_we = 0, tx_valid = 0, rx_ready = 0;
  logic [7:0] ctrl_wdata = 0, tx_data = 0, ctrl_rdata, rx_data;
  logic [9:0] own_addr = {3'b000, A7};
  logic tx_ready, rx_valid, irq_byte, irq_start, irq_stop, scl_oe, sda_oe;
  logic m_scl = 1, m_sda = 1;
  wire scl_line = m_scl & ~scl_oe;
  wire sda_line = m_sda & ~sda_oe;

  i2c_target_port u_i2c_target_port (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .own_addr(own_addr), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .irq_byte(irq_byte),
    .irq_start(irq_start), .irq_stop(irq_stop), .scl_i(scl_line),
    .scl_oe(scl_oe), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  int n_vec = 0, n_bad = 0, n_byte = 0, n_sta = 0, n_sto = 0;
  bit model_active = 0, done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-clock reference: an inactive port must leave both lines alone (R2)
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_byte) n_byte++;
      if (irq_start) n_sta++;
      if (irq_stop) n_sto++;
      if (!model_active) chk("R2 idle lines", {scl_oe, sda_oe}, 2'b00);
    end
  end

  task automatic ctl(input logic [7:0] w);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = w;
    @(negedge clk); ctrl_we = 0;
    model_active = w[7] & w[2] & w[1];
    repeat (2) @(negedge clk);
  endtask

  task automatic txw(input logic [7:0] d);
    @(negedge clk); tx_valid = 1; tx_data = d;
    @(negedge clk); tx_valid = 0;
  endtask

  task automatic rxpop();
    @(negedge clk); rx_ready = 1;
    @(negedge clk); rx_ready = 0;
  endtask

  task automatic hp(); repeat (H) @(negedge clk); endtask
  task automatic sclhi(); m_scl = 1; while (!scl_line) @(negedge clk); endtask

  task automatic m_start(); m_sda = 1; hp(); sclhi(); hp(); m_sda = 0; hp(); m_scl = 0; hp(); endtask
  task automatic m_stop(); m_sda = 0; hp(); sclhi(); hp(); m_sda = 1; hp(); endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hp(); sclhi(); hp(); m_scl = 0;
    end
    m_sda = 1; hp(); sclhi(); repeat (H/2) @(negedge clk);
    ack = ~sda_line; repeat (H/2) @(negedge clk); m_scl = 0; hp();
  endtask

  task automatic rd_byte(input logic ack, output logic [7:0] b);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      hp(); sclhi(); repeat (H/2) @(negedge clk);
      b[i] = sda_line; repeat (H/2) @(negedge clk); m_scl = 0;
    end
    m_sda = ~ack; hp(); sclhi(); hp(); m_scl = 0; hp(); m_sda = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int nb;
    repeat (4) @(negedge clk);
    chk("R1 ctrl", ctrl_rdata, 8'h00);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 oe", {scl_oe, sda_oe}, 2'b00);
    rst_n = 1; repeat (4) @(negedge clk);

    // R3 hold / release
    ctl(8'h86);
    chk("R3 hold", scl_oe, 1);
    ctl(8'hC6);
    chk("R3 release", scl_oe, 0);
    chk("R12 readback", ctrl_rdata, 8'hC6);

    // R4 write, R9 tx write during receive
    nb = n_byte;
    m_start(); wr_byte({A7, 1'b0}, ack); chk("R4 addr ack", ack, 1);
    txw(8'h77); chk("R9 no wcol in rx", ctrl_rdata[5], 0);
    wr_byte(8'hA5, ack); chk("R4 data ack", ack, 1);
    chk("R4 rx", {rx_valid, rx_data}, {1'b1, 8'hA5});
    m_stop();
    chk("R4 irq count", n_byte - nb, 2);
    chk("R11 no start irq", n_sta, 0);

    // R8 overflow
    m_start(); wr_byte({A7, 1'b0}, ack); chk("R8 addr ack", ack, 1);
    wr_byte(8'h5C, ack); chk("R8 nack", ack, 0);
    chk("R8 flag", ctrl_rdata[4], 1);
    chk("R8 kept", rx_data, 8'hA5);
    m_stop();
    rxpop(); ctl(8'hC6);
    chk("R12 ovf cleared", ctrl_rdata, 8'hC6);

    // R5 wrong address
    nb = n_byte;
    m_start(); wr_byte({7'h11, 1'b0}, ack); chk("R5 nack", ack, 0);
    wr_byte(8'h12, ack); chk("R5 data ignored", ack, 0);
    m_stop();
    chk("R5 no irq", n_byte - nb, 0);
    chk("R5 rx empty", rx_valid, 0);

    // fill buffer for R9 then read transfer
    m_start(); wr_byte({A7, 1'b0}, ack); wr_byte(8'h66, ack); m_stop();
    m_start(); wr_byte({A7, 1'b1}, ack); chk("R6 addr ack", ack, 1);
    repeat (8) @(negedge clk);
    chk("R6 release cleared", ctrl_rdata[6], 0);
    chk("R6 scl held", scl_oe, 1);
    txw(8'hC3); ctl(8'hC6);
    fork
      rd_byte(1, b);
      begin
        repeat (3 * 2 * H) @(negedge clk);
        tx_valid = 1; tx_data = 8'hFF; ctrl_we = 1; ctrl_wdata = 8'hC6;
        @(negedge clk); tx_valid = 0; ctrl_we = 0;
      end
    join
    chk("R6 byte", b, 8'hC3);
    chk("R7 collision wins", ctrl_rdata[5], 1);
    repeat (8) @(negedge clk);
    chk("R6 rearmed hold", {ctrl_rdata[6], scl_oe}, 2'b01);
    ctl(8'h86); chk("R7 cleared", ctrl_rdata[5], 0);
    txw(8'h3C); ctl(8'hC6);
    rd_byte(0, b); chk("R6 second byte", b, 8'h3C);
    m_stop();
    chk("R9 no ovf in tx", ctrl_rdata[4], 0);
    rxpop();

    // R2 reserved mode, then disabled
    ctl(8'h82);
    m_start(); wr_byte({A7, 1'b0}, ack); chk("R2 reserved nack", ack, 0); m_stop();
    ctl(8'h06);
    m_start(); wr_byte({A7, 1'b0}, ack); chk("R2 disabled nack", ack, 0); m_stop();

    // R10 10-bit with R11 start/stop pulses
    own_addr = A10;
    ctl(8'hCF);
    nb = n_sta;
    m_start(); chk("R11 start irq", n_sta - nb, 1);
    wr_byte({5'b11110, A10[9:8], 1'b0}, ack); chk("R10 hdr ack", ack, 1);
    wr_byte(A10[7:0], ack); chk("R10 low ack", ack, 1);
    wr_byte(8'h42, ack); chk("R10 data", {ack, rx_data}, {1'b1, 8'h42});
    m_start();
    wr_byte({5'b11110, A10[9:8], 1'b1}, ack); chk("R10 read hdr ack", ack, 1);
    repeat (8) @(negedge clk);
    txw(8'h9E); ctl(8'hCF);
    rd_byte(0, b); chk("R10 read byte", b, 8'h9E);
    nb = n_sto;
    m_stop(); repeat (8) @(negedge clk);
    chk("R11 stop irq", n_sto - nb, 1);
    m_start(); wr_byte({5'b11110, 2'b01, 1'b0}, ack); chk("R10 bad hdr nack", ack, 0);
    m_stop();

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule